// File: doc/BRIEF.md
# Late-Write Flow-Through Synchronous SRAM

This block is a small synchronous static memory whose write data trails its command by one clock. Address, read/write, the three chip selects, the burst-advance input and the per-byte write enables are captured on a rising clock edge. For a write, the data word is taken on the following edge. For a read, the addressed word appears combinationally from the registered address before the next edge. Because both directions have the same one-cycle offset between command and data, reads and writes can follow each other in any order with no idle bus cycle.

A command loaded with burst-advance low starts an operation: read, write or deselect. Each later edge with burst-advance high steps a two-bit burst counter over the low address bits and repeats the same kind of operation. The address, selects and read/write are ignored on those edges. A mode input picks linear or interleaved stepping. An active-low clock enable freezes every register, the pending write and the read output. The read bus has an output-enable indication instead of a real tri-state pin. It is low and the data is zero whenever the memory is deselected, the current operation is not a read, or the output-enable pin is high.

Top module: `lwsram_top`

## Requirements
- R1: After reset the current operation is a deselect, so `rd_drive` is 0 and `rd_data` is 0 until a read is loaded.
- R2: On an enabled edge with `burst_adv` low, the part is selected only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. If selected, `rd_wr_n`=1 loads a read and `rd_wr_n`=0 loads a write. Otherwise a deselect is loaded, which drives `rd_drive` to 0.
- R3: The word on `wr_data` is taken on the enabled edge after a write edge. It is stored at the address registered by that write edge.
- R4: `lane_we_n[i]`=0 on the write edge lets bits [8i+7:8i] of the trailing data be written. Lanes with `lane_we_n[i]`=1 keep their old contents.
- R5: After the edge that registers a read, and before the next edge, `rd_data` shows the stored word at the registered address and `rd_drive` is 1 (with `out_en_n`=0).
- R6: Reads and writes mix in any order, one per cycle. A read issued on the edge that takes the data of a write to the same address returns the merged new word.
- R7: On an enabled edge with `burst_adv` high, `addr`, the selects and `rd_wr_n` are ignored. The previous operation type repeats at the next burst address, with address bits above bit 1 unchanged. Lane enables are still sampled on each such edge for the data of the next edge.
- R8: With `wrap_il`=0 the low two address bits of burst beat n are (start + n) mod 4.
- R9: With `wrap_il`=1 the low two address bits of burst beat n are start XOR n.
- R10: An edge with `clk_en_n`=1 changes nothing. The operation, burst position, lane enables, array and `rd_data` are all held. A pending write takes its data on the next enabled edge.
- R11: `out_en_n`=1 forces `rd_drive` low and `rd_data` to 0 at once. It has no effect on writes.
- R12: Burst-advance edges following a deselect keep the part deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| clk_en_n | input | 1 | Active-low clock enable; high stalls everything |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| burst_adv | input | 1 | 1 = continue the burst, 0 = load a new command |
| lane_we_n | input | BYTES | Active-low write enable per byte lane |
| addr | input | ADDR_W | Word address |
| wrap_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Active-low output enable |
| wr_data | input | 8*BYTES | Write data, one cycle after its command |
| rd_data | output | 8*BYTES | Read data, zero when not driving |
| rd_drive | output | 1 | High when the read bus would be driven |

## Verification
The hardest case to reach is a stall that falls between a write edge and its trailing data edge in the middle of a burst. It must hold both the pending lane enables and the burst position, and then commit the data that is present on the first enabled edge. The stimulus reaches it with write bursts that have clock-enable-high cycles inserted between beats. The bus carries decoy data during those cycles. A read-back burst in both count orders then shows which value landed where. Burst beats are also driven with deasserted selects, a flipped read/write and random addresses, which proves that those inputs are ignored.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lwsram_burst.sv
// Burst address generator: holds the start address and a 2-bit beat count.
module lwsram_burst #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              step,
  input  logic              wrap_il,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [1:0]        low;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = addr_in;
      cnt_d  = 2'd0;
    end else if (step) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    if (wrap_il) low = base_q[1:0] ^ cnt_q;
    else         low = base_q[1:0] + cnt_q;
    addr_q = {base_q[ADDR_W-1:2], low};
  end

  // R7: a burst beat never leaves its aligned group of four words
  assert_burst_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && !load) |=> addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]));
endmodule

// File: rtl/lwsram_ctrl.sv
// Command decode: selects, read/write, burst continuation and lane enables.
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             rd_wr_n,
  input  logic             burst_adv,
  input  logic [BYTES-1:0] lane_we_n,
  output op_e              op_q,
  output logic [BYTES-1:0] be_q
);
  op_e              op_d;
  logic [BYTES-1:0] be_d;
  logic             selected;

  always_comb begin
    selected = !sel_a_n && sel_b && !sel_c_n;
    be_d     = ~lane_we_n;
    op_d     = op_q;
    if (!burst_adv) begin
      if (!selected)    op_d = OP_DESEL;
      else if (rd_wr_n) op_d = OP_READ;
      else              op_d = OP_WRITE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_DESEL;
      be_q <= '0;
    end else if (!clk_en_n) begin
      op_q <= op_d;
      be_q <= be_d;
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(op_q) && $stable(be_q)));
  assert_burst_keeps_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_adv) |=> op_q == $past(op_q));
  assert_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_adv && (sel_a_n || !sel_b || sel_c_n)) |=> op_q == OP_DESEL);
  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_adv && !sel_a_n && sel_b && !sel_c_n && !rd_wr_n) |=> op_q == OP_WRITE);
endmodule

// File: rtl/lwsram_array.sv
// Byte-lane storage: one write port with lane enables, one combinational read.
module lwsram_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [BYTES-1:0]   be,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [8*BYTES-1:0] wdata,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [8*BYTES-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && be[g]) lane_mem[waddr] <= wdata[8*g +: 8];
    end
    assign rdata[8*g +: 8] = lane_mem[raddr];
  end
endmodule

// File: rtl/lwsram_top.sv
module lwsram_top
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en_n,
  input  logic               sel_a_n,
  input  logic               sel_b,
  input  logic               sel_c_n,
  input  logic               rd_wr_n,
  input  logic               burst_adv,
  input  logic [BYTES-1:0]   lane_we_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrap_il,
  input  logic               out_en_n,
  input  logic [8*BYTES-1:0] wr_data,
  output logic [8*BYTES-1:0] rd_data,
  output logic               rd_drive
);
  localparam int DATA_W = 8 * BYTES;

  logic              en;
  op_e               op_q;
  logic [BYTES-1:0]  be_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] arr_rd;
  logic              arr_we;

  assign en     = !clk_en_n;
  assign arr_we = en && (op_q == OP_WRITE);

  lwsram_ctrl #(.BYTES(BYTES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .rd_wr_n(rd_wr_n), .burst_adv(burst_adv), .lane_we_n(lane_we_n),
    .op_q(op_q), .be_q(be_q)
  );

  lwsram_burst #(.ADDR_W(ADDR_W)) i_burst (
    .clk(clk), .rst_n(rst_n), .en(en),
    .load(!burst_adv), .step(burst_adv), .wrap_il(wrap_il),
    .addr_in(addr), .addr_q(cur_addr)
  );

  lwsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) i_array (
    .clk(clk), .we(arr_we), .be(be_q), .waddr(cur_addr),
    .wdata(wr_data), .raddr(cur_addr), .rdata(arr_rd)
  );

  always_comb begin
    rd_drive = (op_q == OP_READ) && !out_en_n;
    rd_data  = rd_drive ? arr_rd : '0;
  end

  // R10: a stalled edge leaves the stored word under the current address untouched
  assert_stall_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(arr_rd));
  // R11: the bus is only driven while output enable is asserted
  assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> (!out_en_n && op_q == OP_READ));
endmodule

// File: tb/test_lwsram_top.sv
module test_lwsram_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic clk_en_n, sel_a_n, sel_b, sel_c_n, rd_wr_n, burst_adv, wrap_il, out_en_n;
  logic [NB-1:0]   lane_we_n;
  logic [AW-1:0]   addr;
  logic [8*NB-1:0] wr_data, rd_data;
  logic            rd_drive;

  int total = 0;
  int bad = 0;
  logic [31:0] mm [64];
  int          m_op;
  logic [5:0]  m_base;
  logic [1:0]  m_cnt;
  logic [3:0]  m_be;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  lwsram_top #(.ADDR_W(AW), .BYTES(NB)) i_lwsram_top (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .rd_wr_n(rd_wr_n), .burst_adv(burst_adv), .lane_we_n(lane_we_n),
    .addr(addr), .wrap_il(wrap_il), .out_en_n(out_en_n),
    .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  function automatic logic [31:0] pat(input int a, input int k);
    return (32'h9E37_79B9 * (a + 1)) ^ (32'h0101_0101 * k);
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [5:0] m_addr();
    logic [1:0] lo;
    lo = wrap_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[5:2], lo};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle at the negedge, update the model at posedge, check at the next negedge
  task automatic step(input logic ck, input logic c1, input logic c2, input logic c3,
                      input logic r, input logic a, input logic [3:0] ben,
                      input logic [5:0] ad, input logic [31:0] wd, input string tag);
    logic [31:0] exp_d;
    logic        exp_oe;
    logic [5:0]  wa;
    clk_en_n = ck; sel_a_n = c1; sel_b = c2; sel_c_n = c3;
    rd_wr_n = r; burst_adv = a; lane_we_n = ben; addr = ad; wr_data = wd;
    @(posedge clk);
    if (!ck) begin
      if (m_op == 2) begin
        wa = m_addr();
        for (int i = 0; i < 4; i++) if (m_be[i]) mm[wa][8*i +: 8] = wd[8*i +: 8];
      end
      m_be = ~ben;
      if (a) m_cnt = m_cnt + 2'd1;
      else begin
        m_op   = (!c1 && c2 && !c3) ? (r ? 1 : 2) : 0;
        m_base = ad;
        m_cnt  = 2'd0;
      end
    end
    @(negedge clk);
    exp_oe = (m_op == 1) && !out_en_n;
    exp_d  = exp_oe ? mm[m_addr()] : 32'h0;
    chk(rd_drive == exp_oe, {tag, " drive"}, {31'h0, rd_drive}, {31'h0, exp_oe});
    chk(rd_data == exp_d, {tag, " data"}, rd_data, exp_d);
  endtask

  task automatic cmd(input logic r, input logic [3:0] ben, input logic [5:0] ad,
                     input logic [31:0] wd, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b0, r, 1'b0, ben, ad, wd, tag);
  endtask

  // burst beat with decoy select/read-write/address values that must be ignored
  task automatic beat(input logic [3:0] ben, input logic [31:0] wd, input string tag);
    logic [31:0] g;
    g = rnd();
    step(1'b0, g[0], g[1], g[2], g[3], 1'b1, ben, g[9:4], wd, tag);
  endtask

  task automatic idle(input logic [31:0] wd, input string tag);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd0, wd, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    rd_wr_n = 1'b1; burst_adv = 1'b0; lane_we_n = '1; addr = '0; wrap_il = 1'b0;
    out_en_n = 1'b0; wr_data = '0;
    m_op = 0; m_base = '0; m_cnt = '0; m_be = '0;
    for (int i = 0; i < 64; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(rd_drive == 1'b0, "R1 drive", {31'h0, rd_drive}, 32'h0);
    chk(rd_data == 32'h0, "R1 data", rd_data, 32'h0);
    idle(32'h0, "R1");

    // R3: fill every word with back-to-back writes, data trailing by one cycle
    for (int a = 0; a < 64; a++) cmd(1'b0, 4'h0, a[5:0], (a == 0) ? 32'h0 : pat(a - 1, 0), "R3");
    idle(pat(63, 0), "R3");
    // R5: flow-through read sweep
    for (int a = 0; a < 64; a++) cmd(1'b1, 4'h0, a[5:0], 32'hDEAD_BEEF, "R5");

    // R6: random mix, including read of a word on the edge that takes its data
    for (int i = 0; i < 400; i++) begin
      logic [31:0] g;
      g = rnd();
      cmd(g[0], g[0] ? 4'hF : 4'h0, {g[5:4], 4'h0} | g[11:8], rnd(), "R6");
      if (g[12]) begin
        cmd(1'b0, 4'h0, g[21:16], rnd(), "R6");
        cmd(1'b1, 4'h0, g[21:16], rnd(), "R6");
      end
    end

    // R4: every lane-enable pattern
    for (int b = 0; b < 16; b++) begin
      cmd(1'b0, 4'h0, 6'd7, 32'h0, "R4");
      cmd(1'b0, b[3:0], 6'd7, pat(7, 1), "R4");
      cmd(1'b1, 4'h0, 6'd7, pat(7, 2), "R4");
      cmd(1'b1, 4'h0, 6'd7, 32'h0, "R4");
    end

    // R7/R8/R9: bursts in both orders from every start offset
    for (int md = 0; md < 2; md++) begin
      wrap_il = md[0];
      for (int s = 0; s < 4; s++) begin
        cmd(1'b0, 4'h0, 6'd40 + s[5:0], 32'h0, md ? "R9" : "R8");
        for (int n = 0; n < 3; n++) beat(4'h0, pat(s + 8 * n, md + 3), "R7");
        idle(pat(s + 30, md + 3), md ? "R9" : "R8");
        cmd(1'b1, 4'h0, 6'd40 + s[5:0], 32'h0, md ? "R9" : "R8");
        for (int n = 0; n < 3; n++) beat(4'h0, 32'h0, md ? "R9" : "R8");
        // lane enables sampled per beat
        cmd(1'b0, 4'hA, 6'd52 + s[5:0], 32'h0, "R7");
        beat(4'h5, rnd(), "R7");
        beat(4'h0, rnd(), "R7");
        beat(4'hC, rnd(), "R7");
        idle(rnd(), "R7");
        cmd(1'b1, 4'h0, 6'd52, 32'h0, "R7");
        for (int n = 0; n < 3; n++) beat(4'h0, 32'h0, "R7");
      end
    end

    // R10: stalls inside write and read bursts with decoy data
    for (int md = 0; md < 2; md++) begin
      wrap_il = md[0];
      cmd(1'b0, 4'h0, 6'd21, 32'h0, "R10");
      for (int n = 0; n < 4; n++) begin
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 6'd0, rnd(), "R10");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 6'd3, rnd(), "R10");
        if (n < 3) beat(4'h0, pat(n, 9), "R10");
        else idle(pat(n, 9), "R10");
      end
      cmd(1'b1, 4'h0, 6'd21, 32'h0, "R10");
      for (int n = 0; n < 3; n++) begin
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 6'd9, rnd(), "R10");
        beat(4'h0, 32'h0, "R10");
      end
    end
    wrap_il = 1'b0;

    // R2/R12: each select alone deselects; bursts after deselect stay deselected
    for (int k = 0; k < 3; k++) begin
      step(1'b0, k == 0, k != 1, k == 2, 1'b1, 1'b0, 4'h0, 6'd5, 32'h0, "R2");
      for (int n = 0; n < 3; n++) beat(4'h0, 32'h0, "R12");
      step(1'b0, k == 0, k != 1, k == 2, 1'b0, 1'b0, 4'h0, 6'd5, 32'h0, "R2");
      idle(32'hFFFF_FFFF, "R2");
      cmd(1'b1, 4'h0, 6'd5, 32'h0, "R2");
    end

    // R11: output enable gates the bus but not writes
    out_en_n = 1'b1;
    cmd(1'b1, 4'h0, 6'd9, 32'h0, "R11");
    cmd(1'b0, 4'h0, 6'd9, 32'h0, "R11");
    cmd(1'b1, 4'h0, 6'd9, pat(9, 7), "R11");
    out_en_n = 1'b0;
    #1;
    chk(rd_drive == 1'b1, "R11 drive", {31'h0, rd_drive}, 32'h1);
    chk(rd_data == pat(9, 7), "R11 data", rd_data, pat(9, 7));
    cmd(1'b1, 4'h0, 6'd9, 32'h0, "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule